// File: doc/BRIEF.md
# GPIO Interrupt and Wakeup Controller

This block watches a bank of general-purpose input pins and turns selected pin activity into service requests. Every pin passes through a two-flop synchroniser and then a detector that can react to a low level, a high level, a rising edge and a falling edge, in any combination. A detected event sets the pin's bit in two status registers, one per interrupt line. Software clears those bits by writing 1; nothing software writes can set them.

Two interrupt outputs are formed from the status registers, each through its own per-pin enable mask, so the same detectors can serve two different consumers. A third output, the wakeup request, is raised for edge events only, and only for pins set in a per-pin wakeup mask while a global wakeup enable is on. All configuration sits behind a small word-wide register port with a one-cycle write strobe and a combinational read.

Top module: `gpio_event_ctrl`

Register map (address on `reg_addr`, one bit per pin in every per-pin register, bit i belongs to pin i): 0 input-enable, 1 low-level detect, 2 high-level detect, 3 rising-edge detect, 4 falling-edge detect, 5 line-1 mask, 6 line-2 mask, 7 wakeup mask, 8 line-1 status (write 1 to clear), 9 line-2 status (write 1 to clear), 10 control (bit 0 = global wakeup enable, other bits read 0). Unmapped addresses read 0 and ignore writes.

## Requirements
- R1: After reset every register reads 0 and `irq1_o`, `irq2_o` and `wake_o` are 0.
- R2: A pin change driven before clock edge E reaches the status registers and the interrupt outputs right after edge E+2 and not before.
- R3: With low-level detect (address 1) set, a pin held at 0 sets its status bits on every cycle; with high-level detect (address 2) set, a pin held at 1 does; with both set, the pin requests continuously at either level.
- R4: Rising-edge detect (address 3) catches 0-to-1 transitions, falling-edge detect (address 4) catches 1-to-0 transitions, and both together catch either transition.
- R5: A pin whose input-enable bit (address 0) is 0 never sets a status bit and never causes a wakeup, whatever its detect settings.
- R6: Writing 1 to a bit of a status register (address 8 or 9) clears that bit on the next edge; writing 0 leaves it unchanged; no write ever sets a status bit.
- R7: When a detected event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R8: `irq1_o` is 1 exactly when some pin has both its line-1 status and line-1 mask bit set, and `irq2_o` likewise with the line-2 status and mask; the two lines are independent.
- R9: `wake_o` pulses for one cycle, in the same cycle the status bits are set, for an edge event on a pin with its wakeup-mask bit (address 7) set while control bit 0 (address 10) is 1; level events never raise it.
- R10: Every configuration register reads back the value last written to it at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | NPIN | Write data |
| reg_rdata_o | output | NPIN | Read data for `reg_addr_i`, combinational |
| irq1_o | output | 1 | Interrupt line 1 request |
| irq2_o | output | 1 | Interrupt line 2 request |
| wake_o | output | 1 | Wakeup request pulse |

## Verification
A pin change driven between edges is due at the status registers, both interrupt lines and the wakeup output right after the third following edge, since it crosses two synchroniser flops and the status flop; a register write takes effect right after its own edge, and reads are combinational. The bench keeps a behavioural reference model that records the pin history sampled at each edge and evaluates detection two and three samples back, so its predictions land on exactly those cycles. Outputs are compared against the model on every falling edge, register reads are checked one time unit after the address settles, and a directed sequence counts the edges of the synchroniser latency explicitly.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_INPUT_EN = 4'd0,
        SEL_DET_LOW  = 4'd1,
        SEL_DET_HIGH = 4'd2,
        SEL_DET_RISE = 4'd3,
        SEL_DET_FALL = 4'd4,
        SEL_LINE1_EN = 4'd5,
        SEL_LINE2_EN = 4'd6,
        SEL_WAKE_EN  = 4'd7,
        SEL_STAT1    = 4'd8,
        SEL_STAT2    = 4'd9,
        SEL_CTRL     = 4'd10
    } reg_sel_e;

    localparam int CTRL_WAKE_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [LAST:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[LAST-1:0], async_i[b]};
        end
        assign sync_o[b] = chain[LAST];
    end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] in_en_i,
    input  logic [W-1:0] low_en_i,
    input  logic [W-1:0] high_en_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] edge_evt_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rose, fell, lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp_i;
    end

    always_comb begin
        rose       = smp_i & ~prev_q;
        fell       = ~smp_i & prev_q;
        lvl_hit    = (low_en_i & ~smp_i) | (high_en_i & smp_i);
        edge_evt_o = in_en_i & ((rise_en_i & rose) | (fall_en_i & fell));
        evt_o      = edge_evt_o | (in_en_i & lvl_hit);
    end

    // a qualified rising transition must be flagged as an edge event
    assert_rise_caught_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en_i & rise_en_i & smp_i & ~$past(smp_i) & ~edge_evt_o) == '0);

    // a qualified falling transition must be flagged as an edge event
    assert_fall_caught_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en_i & fall_en_i & ~smp_i & $past(smp_i) & ~edge_evt_o) == '0);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_evt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      evt_i,
    input  logic [W-1:0]      edge_evt_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      in_en_o,
    output logic [W-1:0]      low_en_o,
    output logic [W-1:0]      high_en_o,
    output logic [W-1:0]      rise_en_o,
    output logic [W-1:0]      fall_en_o,
    output logic [W-1:0]      line1_en_o,
    output logic [W-1:0]      line2_en_o,
    output logic [W-1:0]      stat1_o,
    output logic [W-1:0]      stat2_o,
    output logic              wake_o
);
    logic [W-1:0] wake_en_q;
    logic         wake_glb_q;
    logic [W-1:0] clr1, clr2;
    logic         wake_d;
    reg_sel_e     sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        clr1   = (we_i && sel == SEL_STAT1) ? wdata_i : '0;
        clr2   = (we_i && sel == SEL_STAT2) ? wdata_i : '0;
        wake_d = wake_glb_q && ((edge_evt_i & wake_en_q) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_en_o    <= '0;
            low_en_o   <= '0;
            high_en_o  <= '0;
            rise_en_o  <= '0;
            fall_en_o  <= '0;
            line1_en_o <= '0;
            line2_en_o <= '0;
            wake_en_q  <= '0;
            wake_glb_q <= 1'b0;
        end else if (we_i) begin
            unique case (sel)
                SEL_INPUT_EN: in_en_o    <= wdata_i;
                SEL_DET_LOW:  low_en_o   <= wdata_i;
                SEL_DET_HIGH: high_en_o  <= wdata_i;
                SEL_DET_RISE: rise_en_o  <= wdata_i;
                SEL_DET_FALL: fall_en_o  <= wdata_i;
                SEL_LINE1_EN: line1_en_o <= wdata_i;
                SEL_LINE2_EN: line2_en_o <= wdata_i;
                SEL_WAKE_EN:  wake_en_q  <= wdata_i;
                SEL_CTRL:     wake_glb_q <= wdata_i[CTRL_WAKE_BIT];
                default:      ;
            endcase
        end
    end

    // event set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat1_o <= '0;
            stat2_o <= '0;
            wake_o  <= 1'b0;
        end else begin
            stat1_o <= (stat1_o & ~clr1) | evt_i;
            stat2_o <= (stat2_o & ~clr2) | evt_i;
            wake_o  <= wake_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_INPUT_EN: rdata_o = in_en_o;
            SEL_DET_LOW:  rdata_o = low_en_o;
            SEL_DET_HIGH: rdata_o = high_en_o;
            SEL_DET_RISE: rdata_o = rise_en_o;
            SEL_DET_FALL: rdata_o = fall_en_o;
            SEL_LINE1_EN: rdata_o = line1_en_o;
            SEL_LINE2_EN: rdata_o = line2_en_o;
            SEL_WAKE_EN:  rdata_o = wake_en_q;
            SEL_STAT1:    rdata_o = stat1_o;
            SEL_STAT2:    rdata_o = stat2_o;
            SEL_CTRL:     rdata_o[CTRL_WAKE_BIT] = wake_glb_q;
            default:      rdata_o = '0;
        endcase
    end

    // a status bit may only rise when the detector reported that pin
    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1_o & ~$past(stat1_o) & ~$past(evt_i)) == '0) &&
        ((stat2_o & ~$past(stat2_o) & ~$past(evt_i)) == '0));

    // a write-1 on a quiet pin clears the bit on the next edge
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_STAT1) |=> ((stat1_o & $past(wdata_i & ~evt_i)) == '0));

    // detected events always land in both status registers
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> (((stat1_o & $past(evt_i)) == $past(evt_i)) &&
                           ((stat2_o & $past(evt_i)) == $past(evt_i))));

    // wakeup only follows a masked edge event under the global enable
    assert_wake_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(wake_glb_q) && (($past(edge_evt_i) & $past(wake_en_q)) != '0)));
endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [NPIN-1:0]   reg_wdata_i,
    output logic [NPIN-1:0]   reg_rdata_o,
    output logic              irq1_o,
    output logic              irq2_o,
    output logic              wake_o
);
    logic [NPIN-1:0] smp, evt, edge_evt;
    logic [NPIN-1:0] in_en, low_en, high_en, rise_en, fall_en;
    logic [NPIN-1:0] line1_en, line2_en, stat1, stat2;

    gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(smp)
    );

    gpio_detect #(.W(NPIN)) u_detect (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .in_en_i(in_en),
        .low_en_i(low_en), .high_en_i(high_en), .rise_en_i(rise_en),
        .fall_en_i(fall_en), .evt_o(evt), .edge_evt_o(edge_evt)
    );

    gpio_regs #(.W(NPIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .evt_i(evt), .edge_evt_i(edge_evt),
        .rdata_o(reg_rdata_o), .in_en_o(in_en), .low_en_o(low_en),
        .high_en_o(high_en), .rise_en_o(rise_en), .fall_en_o(fall_en),
        .line1_en_o(line1_en), .line2_en_o(line2_en),
        .stat1_o(stat1), .stat2_o(stat2), .wake_o(wake_o)
    );

    assign irq1_o = |(stat1 & line1_en);
    assign irq2_o = |(stat2 & line2_en);

    // a disabled input never produces a detector event
    assert_input_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~in_en) == '0);

    // a line may only rise after a status bit or its mask changed
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq1_o) |-> (($past(evt) != '0) || ($past(line1_en) != line1_en)));
endmodule

// File: tb/test_gpio_event_ctrl.sv
module test_gpio_event_ctrl;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic          we = 1'b0;
    logic [3:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic          irq1, irq2, wake;

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;

    gpio_event_ctrl #(.NPIN(NP)) i_gpio_event_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq1_o(irq1), .irq2_o(irq2), .wake_o(wake)
    );

    always #5 clk = ~clk;

    // reference model: pin history and register contents
    logic [NP-1:0] cfg [0:10];
    logic [NP-1:0] h0, h1, h2;
    logic          m_wake;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a <= 10; a++) cfg[a] = '0;
            h0 = '0; h1 = '0; h2 = '0; m_wake = 0;
        end else begin
            logic [NP-1:0] ev, edg;
            for (int b = 0; b < NP; b++) begin
                bit cur, old, on;
                cur = h1[b]; old = h2[b]; on = cfg[0][b];
                edg[b] = on && ((cfg[3][b] && cur && !old) || (cfg[4][b] && !cur && old));
                ev[b]  = edg[b] || (on && ((cfg[1][b] && !cur) || (cfg[2][b] && cur)));
            end
            m_wake = cfg[10][0] && ((edg & cfg[7]) != 0);
            if (we && addr <= 10) begin
                if (addr == 8 || addr == 9) cfg[addr] = cfg[addr] & ~wdata;
                else if (addr == 10)        cfg[10] = {{(NP-1){1'b0}}, wdata[0]};
                else                        cfg[addr] = wdata;
            end
            cfg[8] = cfg[8] | ev;
            cfg[9] = cfg[9] | ev;
            h2 = h1; h1 = h0; h0 = pin;
        end
    end

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        chk("R8 irq1", {7'd0, irq1}, {7'd0, (cfg[8] & cfg[5]) != 0});
        chk("R8 irq2", {7'd0, irq2}, {7'd0, (cfg[9] & cfg[6]) != 0});
        chk("R9 wake", {7'd0, wake}, {7'd0, m_wake});
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
        we = 1; addr = a; wdata = d;
        tick();
        we = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [NP-1:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked while reset is still held
        chk("R1 irq1", {7'd0, irq1}, '0);
        chk("R1 wake", {7'd0, wake}, '0);
        rst_n = 1;
        tick();
        for (int a = 0; a <= 10; a++) rd("R1 reset reg", a[3:0], '0);
        cmp_on = 1;

        // R10 readback
        wr(5, 8'hA5); wr(6, 8'h3C); wr(7, 8'h81);
        rd("R10 line1 mask", 5, 8'hA5);
        rd("R10 line2 mask", 6, 8'h3C);
        rd("R10 wake mask", 7, 8'h81);
        wr(10, 8'hFF);
        rd("R10 ctrl", 10, 8'h01);
        wr(5, 8'hFF); wr(6, 8'h00); wr(10, 8'h00);

        // R5 inputs disabled: level detect on a low pin does nothing
        wr(1, 8'hFF); wr(3, 8'hFF);
        pin = 8'h0F; tick(5); pin = 8'h00; tick(5);
        rd("R5 disabled stat1", 8, 8'h00);
        rd("R5 disabled stat2", 9, 8'h00);
        wr(1, 8'h00);

        // R2 latency: rising edge on pin0
        wr(0, 8'hFF);
        pin = 8'h01;
        tick(); chk("R2 edge1", {7'd0, irq1}, '0);
        tick(); chk("R2 edge2", {7'd0, irq1}, '0);
        tick(); chk("R2 edge3", {7'd0, irq1}, 8'h01);
        rd("R4 rise stat1", 8, 8'h01);

        // R6 write 0 keeps, write 1 clears, never sets
        wr(8, 8'h00); rd("R6 w0 keeps", 8, 8'h01);
        wr(8, 8'h01); rd("R6 w1 clears", 8, 8'h00);
        rd("R6 stat2 untouched", 9, 8'h01);
        wr(9, 8'hFF); wr(8, 8'hFE); rd("R6 no set", 8, 8'h00);

        // R4 falling and both edges
        wr(3, 8'h00); wr(4, 8'h02);
        pin = 8'h03; tick(4); rd("R4 fall ignores rise", 8, 8'h00);
        pin = 8'h01; tick(4); rd("R4 fall", 8, 8'h02);
        wr(8, 8'hFF); wr(3, 8'h04); wr(4, 8'h04);
        pin = 8'h05; tick(4); rd("R4 both rise", 8, 8'h04);
        wr(8, 8'hFF);
        pin = 8'h01; tick(4); rd("R4 both fall", 8, 8'h04);
        wr(8, 8'hFF); wr(9, 8'hFF); wr(3, 0); wr(4, 0);

        // R3 levels, and both levels giving a constant request
        wr(2, 8'h10); pin = 8'h10; tick(4);
        wr(8, 8'h10); rd("R3 high level holds", 8, 8'h10);
        wr(2, 0); wr(1, 8'h20); wr(8, 8'hFF); tick(); rd("R3 low level", 8, 8'h20);
        wr(2, 8'h20); pin = 8'h30; tick(4);
        // R7 clear collides with live event: bit stays set
        wr(8, 8'h20); rd("R7 event wins", 8, 8'h20);
        pin = 8'h10; tick(4);
        wr(8, 8'h20); rd("R3 both levels constant", 8, 8'h20);
        wr(1, 0); wr(2, 0); tick(); wr(8, 8'hFF); wr(9, 8'hFF);

        // R8 independent lines
        wr(5, 8'h00); wr(6, 8'h40); wr(3, 8'h40);
        pin = 8'h50; tick(4);
        chk("R8 line2 only", {6'd0, irq2, irq1}, 8'h02);
        wr(9, 8'h40); chk("R8 line2 cleared", {6'd0, irq2, irq1}, 8'h00);
        wr(8, 8'hFF); wr(5, 8'hFF);

        // R9 wakeup: level never, needs mask and global enable
        wr(7, 8'h80); wr(2, 8'h80); wr(10, 1);
        pin = 8'hD0; tick(4); rd("R9 level sets stat", 8, 8'h80);
        wr(2, 0); wr(3, 8'h80); wr(8, 8'hFF); wr(10, 0);
        pin = 8'h50; tick(2); pin = 8'hD0; tick(4);
        wr(10, 1); wr(8, 8'hFF);
        pin = 8'h50; tick(2); pin = 8'hD0; tick(2);
        tick(); chk("R9 wake pulse", {7'd0, wake}, 8'h01);
        tick(); chk("R9 wake one cycle", {7'd0, wake}, 8'h00);

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4) pin = NP'($urandom);
            if (r >= 6) begin
                we = 1; addr = 4'($urandom_range(0, 11)); wdata = NP'($urandom);
            end else we = 0;
            tick();
            we = 0;
            if (i % 50 == 0) begin
                rd("R6 random stat1", 8, cfg[8]);
                rd("R6 random stat2", 9, cfg[9]);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule